// File: doc/BRIEF.md
# Serial LCD Byte Writer

This block sends one byte at a time to a graphic display controller over a four-wire serial link. The four wires are an active-low select, a line that marks the byte as data or command, a serial clock and a serial data line. A producer offers a byte and a type flag on a valid/ready handshake. The block then lowers the select line and holds the type line for the whole byte. It shifts the eight bits out most significant first, then raises the select line again.

The clock low and clock high phases each last a parameterised number of system clock cycles. The data line changes only at a falling serial clock edge, so the display can sample it on the rising edge. The serial clock rests high whenever no bit is being shifted. After the select line has been high for one high phase, a one-cycle done pulse is raised. In that same cycle ready returns, so a producer that holds valid can stream bytes with no dead cycles beyond the framing.

Top module: `lcd_serial_writer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, select is high (1), serial clock is high (1), data and type lines are low (0), ready is high (1) and done is low (0).
- R2: A byte is taken at a clock edge where in_valid and in_ready are both 1. in_ready is 0 from the cycle after that edge until the select line has been high for HIGH_CYC cycles.
- R3: Select (active low, 0 = selected) falls in the cycle after acceptance and stays low for exactly HIGH_CYC + 8*(LOW_CYC+HIGH_CYC) cycles, which frames exactly one byte.
- R4: The type line is 1 for a data byte (in_is_data = 1) and 0 for a command byte (in_is_data = 0). It takes that value when select falls and holds it until the next accepted byte.
- R5: The eight bits go out with bit 7 first and bit 0 last. Each bit appears on the data line in the same cycle the serial clock falls, and it stays there through the following high phase.
- R6: After select falls, the serial clock stays high for HIGH_CYC cycles. For each bit it is then low for LOW_CYC cycles and high for HIGH_CYC cycles. It is high whenever select is high.
- R7: done is 1 for exactly one cycle, HIGH_CYC cycles after select rises. In that cycle select and ready are both 1.
- R8: While a byte is being sent, changes on in_valid, in_byte and in_is_data have no effect on any output.
- R9: A byte offered in the done cycle is accepted at the next edge, and its select low starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| lcd_cs_n | output | 1 | Active-low select to the display |
| lcd_dc | output | 1 | Data (1) / command (0) line |
| lcd_sck | output | 1 | Serial clock, idles high |
| lcd_sda | output | 1 | Serial data, MSB first |
| done | output | 1 | One-cycle pulse at end of a byte |

## Verification
The writer is driven with data and command bytes of 0xA5, 0x3C, 0x00, 0xFF, 0x80 and 0x01. Alternating and single-bit patterns show whether the bit order or the bit count is wrong. All-zero and all-one bytes show whether the data line holds or moves between bits. One transfer gets a changing byte and valid pulses in the middle of it, to show that the captured value is kept. A pair of back-to-back bytes with valid held high shows whether the done cycle and ready line up.

// File: rtl/lcd_ser_pkg.sv
package lcd_ser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_LOW  = 3'd2,
        ST_HIGH = 3'd3,
        ST_TAIL = 3'd4
    } wr_state_e;

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcd_bit_shifter.sv
module lcd_bit_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            shift,
    output logic            msb
);
    logic [BITS-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)
            sr_d = load_val;
        else if (shift)
            sr_d = {sr_q[BITS-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else
            sr_q <= sr_d;
    end

    assign msb = sr_q[BITS-1];

endmodule

// File: rtl/lcd_serial_writer.sv
module lcd_serial_writer
    import lcd_ser_pkg::*;
#(
    parameter int BITS     = 8,
    parameter int LOW_CYC  = 3,
    parameter int HIGH_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [BITS-1:0] in_byte,
    input  logic            in_is_data,
    output logic            lcd_cs_n,
    output logic            lcd_dc,
    output logic            lcd_sck,
    output logic            lcd_sda,
    output logic            done
);
    localparam int MAXP = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXP) + 1;
    localparam int BCW  = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [CW-1:0]  LOW_LOAD  = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0]  HIGH_LOAD = CW'(HIGH_CYC - 1);
    localparam logic [BCW-1:0] LAST_BIT  = BCW'(BITS - 1);

    typedef struct packed {
        wr_state_e      state;
        logic [BCW-1:0] bit_idx;
        logic           cs_n;
        logic           dc;
        logic           sck;
        logic           sda;
        logic           ready;
        logic           done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          phase_end;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          sh_load;
    logic          sh_shift;
    logic          sh_msb;

    lcd_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (phase_end)
    );

    lcd_bit_shifter #(.BITS(BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (in_byte),
        .shift    (sh_shift),
        .msb      (sh_msb)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (in_valid && ctl_q.ready) begin
                    sh_load     = 1'b1;
                    ctl_d.state = ST_LEAD;
                    ctl_d.cs_n  = 1'b0;
                    ctl_d.dc    = in_is_data;
                    ctl_d.ready = 1'b0;
                    ctl_d.bit_idx = '0;
                end
            end
            ST_LEAD: begin
                if (phase_end) begin
                    ctl_d.state = ST_LOW;
                    ctl_d.sck   = 1'b0;
                    ctl_d.sda   = sh_msb;
                end
            end
            ST_LOW: begin
                if (phase_end) begin
                    ctl_d.state = ST_HIGH;
                    ctl_d.sck   = 1'b1;
                    sh_shift    = 1'b1;
                end
            end
            ST_HIGH: begin
                if (phase_end) begin
                    if (ctl_q.bit_idx == LAST_BIT) begin
                        ctl_d.state = ST_TAIL;
                        ctl_d.cs_n  = 1'b1;
                    end else begin
                        ctl_d.state   = ST_LOW;
                        ctl_d.sck     = 1'b0;
                        ctl_d.sda     = sh_msb;
                        ctl_d.bit_idx = ctl_q.bit_idx + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (phase_end) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.ready = 1'b1;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        tmr_load = (ctl_d.state != ctl_q.state) && (ctl_d.state != ST_IDLE);
        tmr_val  = (ctl_d.state == ST_LOW) ? LOW_LOAD : HIGH_LOAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.bit_idx <= '0;
            ctl_q.cs_n    <= 1'b1;
            ctl_q.dc      <= 1'b0;
            ctl_q.sck     <= 1'b1;
            ctl_q.sda     <= 1'b0;
            ctl_q.ready   <= 1'b1;
            ctl_q.done    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready = ctl_q.ready;
    assign lcd_cs_n = ctl_q.cs_n;
    assign lcd_dc   = ctl_q.dc;
    assign lcd_sck  = ctl_q.sck;
    assign lcd_sda  = ctl_q.sda;
    assign done     = ctl_q.done;

    // R2: never ready while the display is selected
    assert_busy_while_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_cs_n |-> !in_ready);

    // R4: type line frozen across the select window
    assert_dc_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_dc));

    // R5: data stable while clock stays high inside a byte
    assert_sda_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_sck && $past(lcd_sck) && !lcd_cs_n) |-> $stable(lcd_sda));

    // R6: clock rests high outside the select window
    assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cs_n |-> lcd_sck);

    // R7: done is a single-cycle pulse, with select released and ready back
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_framing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lcd_cs_n && in_ready));

    // R3: select rises only from a clock-high phase
    assert_cs_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |-> $past(lcd_sck));

endmodule

// File: tb/lcd_serial_writer_test.sv
module lcd_serial_writer_test;
    localparam int LC = 3;
    localparam int HC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_is_data = 1'b0;
    logic       in_ready, lcd_cs_n, lcd_dc, lcd_sck, lcd_sda, done;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit started = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    lcd_serial_writer #(.BITS(8), .LOW_CYC(LC), .HIGH_CYC(HC)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_data(in_is_data), .lcd_cs_n(lcd_cs_n),
        .lcd_dc(lcd_dc), .lcd_sck(lcd_sck), .lcd_sda(lcd_sda), .done(done)
    );

    typedef struct packed {
        logic cs_n; logic dc; logic sck; logic sda; logic ready; logic done;
    } smp_t;

    localparam smp_t RST_VAL = '{cs_n:1'b1, dc:1'b0, sck:1'b1, sda:1'b0, ready:1'b1, done:1'b0};

    smp_t q[$];
    smp_t e = RST_VAL;

    task automatic push_byte(input logic [7:0] b, input logic f);
        smp_t s;
        logic last;
        last = e.sda;
        for (int i = 0; i < HC; i++) begin
            s = '{1'b0, f, 1'b1, last, 1'b0, 1'b0}; q.push_back(s);
        end
        for (int k = 7; k >= 0; k--) begin
            last = b[k];
            for (int i = 0; i < LC; i++) begin
                s = '{1'b0, f, 1'b0, last, 1'b0, 1'b0}; q.push_back(s);
            end
            for (int i = 0; i < HC; i++) begin
                s = '{1'b0, f, 1'b1, last, 1'b0, 1'b0}; q.push_back(s);
            end
        end
        for (int i = 0; i < HC; i++) begin
            s = '{1'b1, f, 1'b1, last, 1'b0, 1'b0}; q.push_back(s);
        end
        s = '{1'b1, f, 1'b1, last, 1'b1, 1'b1}; q.push_back(s);
    endtask

    always @(posedge clk) begin
        cycles++;
        started = 1'b1;
        if (!rst_n) begin
            e = RST_VAL;
            q.delete();
        end else begin
            if (e.ready && in_valid) push_byte(in_byte, in_is_data);
            if (q.size() > 0) e = q.pop_front();
            else begin e.done = 1'b0; e.ready = 1'b1; end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp_v);
        if (act !== exp_v) begin
            mismatched++;
            $display("FAIL %s [%s] t=%0t actual=%b expected=%b", req, tag, $time, act, exp_v);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            compared++;
            chk("R3 cs_n", lcd_cs_n, e.cs_n);
            chk("R4 dc", lcd_dc, e.dc);
            chk("R6 sck", lcd_sck, e.sck);
            chk("R5 sda", lcd_sda, e.sda);
            chk("R2 ready", in_ready, e.ready);
            chk("R7 done", done, e.done);
        end
    end

    task automatic send(input logic [7:0] b, input logic f, input bit poke_busy);
        @(negedge clk);
        in_byte = b; in_is_data = f; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (poke_busy) begin
            // R8: inputs toggled mid-transfer must leave the outputs alone
            for (int i = 0; i < 12; i++) begin
                in_byte = 8'h5A ^ 8'(i * 37); in_is_data = ~f; in_valid = i[0];
                @(negedge clk);
            end
            in_valid = 1'b0;
        end
        while (!in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        tag = "R5 data A5";  send(8'hA5, 1'b1, 1'b0);
        tag = "R4 cmd 3C";   send(8'h3C, 1'b0, 1'b0);
        tag = "R5 data 00";  send(8'h00, 1'b1, 1'b0);
        tag = "R6 cmd FF";   send(8'hFF, 1'b0, 1'b0);
        tag = "R5 cmd 80";   send(8'h80, 1'b0, 1'b0);
        tag = "R5 data 01";  send(8'h01, 1'b1, 1'b0);
        tag = "R8 busy pokes"; send(8'hC3, 1'b1, 1'b1);
        // R9: valid held across two bytes
        tag = "R9 back-to-back";
        @(negedge clk);
        in_byte = 8'h96; in_is_data = 1'b0; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_byte = 8'h69; in_is_data = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        mismatched++;
        $display("FAIL watchdog expired, actual=%0d cycles expected=<20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule